// File: doc/BRIEF.md
# Transmit Enable Wake-Up Sequencer

This block sits in front of a converter's output and decides, cycle by cycle, whether samples reach the output. The decision follows an asynchronous transmit-enable pin. A falling transition on the pin clamps the output to zero at once. A later rising transition starts a wake-up wait, and the output is released only when that wait ends. The wait has two parts. First the block counts ticks of a strobe that runs at one sixty-fourth of the sample clock. Then it waits a fixed tail of full-rate cycles. An 8-bit setting, read when the wait starts, selects the number of slow ticks.

The rising transition also starts a flush request of fixed length. Downstream logic uses it to drain stale samples while the output is still held at zero. The slow strobe runs freely from reset and is not aligned to the enable. The time to release can therefore vary by up to one strobe period, depending on where the enable rise falls within that period. The clamp responds only to a high-to-low transition of the pin. A pin that is already low when reset ends does not mute the output.

Top module: `txen_wake_seq`

## Requirements
- R1: While reset is held and after it is released, tx_active is 1, dout equals din and flush is 0, whatever the pin level. A pin that is low at reset release causes no clamp.
- R2: A high-to-low transition of txen_pin passes through a two-flop synchronizer. If the pin is low at the rising clock edge with index a, tx_active is still 1 after edge a+1 and is 0 after edge a+2. Whenever tx_active is 0, dout is 0.
- R3: Number the rising edges from 0, where edge 0 is the first edge at which reset is released. The slow strobe counts at edges whose index is 63 mod 64. A rise of txen_pin first seen at edge a while clamped starts the wait after edge a+2. Only strobe edges from a+3 onward count toward the wait.
- R4: A delay_sel value of 0x20 selects 12 strobe ticks and 0x60 selects 19. Every other value selects 1.
- R5: After the last required strobe edge E, tx_active rises after edge E+10. From that cycle on, dout equals din.
- R6: flush is 1 for exactly 175 cycles, starting after edge a+2, when a wait starts.
- R7: A falling transition during a wait clamps as in R2, ends the wait and drops flush at the same edge. A later rise restarts the whole sequence.
- R8: A rise of txen_pin while samples are passing is ignored. flush stays 0 and the output keeps passing.
- R9: delay_sel is captured at the edge where the wait starts. Changes after that edge do not alter the release time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txen_pin | input | 1 | Asynchronous transmit-enable pin |
| delay_sel | input | 8 | Wake-up delay setting |
| din | input | DATA_W | Incoming sample |
| dout | output | DATA_W | Outgoing sample, zero while clamped or waiting |
| flush | output | 1 | Datapath flush request |
| tx_active | output | 1 | High while samples are passed through |

## Verification
The no-extended-delay setting is started at all 64 phases of the enable rise relative to the free-running strobe. This sweep separates a design that counts from the rise from one that counts the shared strobe, and it shows the one-tick spread at the period boundary. The two long settings and five unselected codes are started at phases bunched around the strobe edge. These runs separate correct decoding and capture from a design that decodes loosely or reads the setting late; the setting is changed in the middle of each wait to test capture. Aborts in the slow phase and in the tail, followed by a restart, show that a fall resets both the wait and the flush. A rise while samples are passing and a pin held low through reset show that only transitions count.

// File: rtl/txen_wake_seq.sv
module txen_wake_seq #(
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 6,
  parameter int TAIL_CYC   = 10,
  parameter int FLUSH_CYC  = 175,
  parameter int BASE_TICKS = 1,
  parameter int MID_TICKS  = 12,
  parameter int LONG_TICKS = 19,
  parameter logic [7:0] MID_CODE  = 8'h20,
  parameter logic [7:0] LONG_CODE = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txen_pin,
  input  logic [7:0]        delay_sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              flush,
  output logic              tx_active
);
  localparam int EW = $clog2(LONG_TICKS + 1);
  localparam int TW = $clog2(TAIL_CYC + 1);
  localparam int FW = $clog2(FLUSH_CYC + 1);
  localparam logic [1:0] S_RUN = 2'd0, S_CLAMP = 2'd1, S_WAIT = 2'd2, S_TAIL = 2'd3;

  logic [DIV_W-1:0] div_q;
  logic [1:0]       sync_q;
  logic             en_q;
  logic [1:0]       prime_q;
  logic [1:0]       state;
  logic [EW-1:0]    tick_q, goal_q, goal_d;
  logic [TW-1:0]    tail_q;
  logic [FW-1:0]    fl_q;

  wire strobe = &div_q;
  wire primed = (prime_q == 2'd3);
  wire rise   = primed &  sync_q[1] & ~en_q;
  wire fall   = primed & ~sync_q[1] &  en_q;

  assign goal_d = (delay_sel == MID_CODE)  ? EW'(MID_TICKS)  :
                  (delay_sel == LONG_CODE) ? EW'(LONG_TICKS) : EW'(BASE_TICKS);

  assign tx_active = (state == S_RUN);
  assign dout      = tx_active ? din : '0;
  assign flush     = (fl_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      sync_q  <= '0;
      en_q    <= 1'b0;
      prime_q <= '0;
    end else begin
      div_q   <= div_q + DIV_W'(1);
      sync_q  <= {sync_q[0], txen_pin};
      en_q    <= sync_q[1];
      if (!primed) prime_q <= prime_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fl_q <= '0;
    else if (fall)                   fl_q <= '0;
    else if (state == S_CLAMP && rise) fl_q <= FW'(FLUSH_CYC);
    else if (fl_q != '0)             fl_q <= fl_q - FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_RUN;
      tick_q <= '0;
      goal_q <= '0;
      tail_q <= '0;
    end else if (fall) begin
      state <= S_CLAMP;
    end else begin
      case (state)
        S_CLAMP: if (rise) begin
          state  <= S_WAIT;
          goal_q <= goal_d;
          tick_q <= '0;
        end
        S_WAIT: if (strobe) begin
          if (tick_q == goal_q - EW'(1)) begin
            state  <= S_TAIL;
            tail_q <= '0;
          end else begin
            tick_q <= tick_q + EW'(1);
          end
        end
        S_TAIL: begin
          if (tail_q == TW'(TAIL_CYC - 1)) state <= S_RUN;
          else                             tail_q <= tail_q + TW'(1);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txen_wake_seq_chk.sv
module txen_wake_seq_chk #(
  parameter int DATA_W    = 16,
  parameter int TAIL_CYC  = 10,
  parameter int FLUSH_CYC = 175
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        state,
  input logic              rise,
  input logic              fall,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              flush,
  input logic              tx_active
);
  localparam logic [1:0] S_RUN = 2'd0, S_CLAMP = 2'd1, S_WAIT = 2'd2, S_TAIL = 2'd3;
  int fl_run, tail_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_run   <= 0;
      tail_run <= 0;
    end else begin
      fl_run   <= flush ? fl_run + 1 : 0;
      tail_run <= (state == S_TAIL) ? tail_run + 1 : 0;
    end
  end

  AST_MUTED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !tx_active |-> dout == '0); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) tx_active |-> dout == din); // R5
  AST_CLAMP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CLAMP && $past(state) != S_CLAMP) |-> $past(fall)); // R2
  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && $past(state) != S_WAIT) |-> ($past(state) == S_CLAMP && $past(rise) && flush)); // R3
  AST_TAIL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_active) |-> tail_run == TAIL_CYC); // R5
  AST_FLUSH_CAP: assert property (@(posedge clk) disable iff (!rst_n) flush |-> fl_run < FLUSH_CYC); // R6
  AST_FLUSH_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> (fl_run == FLUSH_CYC || $past(fall))); // R7
  AST_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && rise) |=> (state == S_RUN && !$rose(flush))); // R8
endmodule

bind txen_wake_seq txen_wake_seq_chk #(
  .DATA_W(DATA_W), .TAIL_CYC(TAIL_CYC), .FLUSH_CYC(FLUSH_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .rise(rise), .fall(fall),
  .din(din), .dout(dout), .flush(flush), .tx_active(tx_active)
);

// File: tb/txen_wake_seq_test.sv
module txen_wake_seq_test;
  localparam int DW = 16;
  localparam int FL = 175;

  logic clk = 0, rst_n = 0, pin = 0;
  logic [7:0] cfg = 8'h00;
  logic [DW-1:0] din = 16'h1234;
  logic [DW-1:0] dout;
  logic flush, tx_active;
  int ec = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) ec <= ec + 1;
  always @(posedge clk) din <= din + 16'h3a5d;

  txen_wake_seq #(.DATA_W(DW), .FLUSH_CYC(FL)) uut (
    .clk(clk), .rst_n(rst_n), .txen_pin(pin), .delay_sel(cfg), .din(din),
    .dout(dout), .flush(flush), .tx_active(tx_active));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  function automatic int ticks_for(input logic [7:0] c);
    if (c == 8'h20) return 12;
    if (c == 8'h60) return 19;
    return 1;
  endfunction

  task automatic drop_pin;
    int a;
    a = ec;
    pin = 0;
    step; step;
    chk(tx_active == 1, "R2 still passing one edge after sync", tx_active, 1);
    step;
    chk(tx_active == 0 && dout == 0, "R2 clamp after sync", {tx_active, dout}, 0);
  endtask

  // mode 0: full wake, 1: abort in tail, 2: abort in slow count
  task automatic wake(input logic [7:0] c, input int phase, input int mode);
    int a, e1, r, b, fend, lim, bad_tx, bad_fl, bad_d, got_tx, got_fl;
    bit exp_tx, exp_fl;
    while (ec % 64 != phase) step;
    a = ec;
    cfg = c;
    pin = 1;
    e1 = a + 3 + (63 - ((a + 3) % 64));
    r = e1 + 64 * (ticks_for(c) - 1) + 10;
    b = (mode == 1) ? r - 5 : (mode == 2) ? a + 200 : -1;
    fend = a + 2 + FL;
    if (b >= 0 && b + 2 < fend) fend = b + 2;
    lim = ((r + 1 > fend + 1) ? r + 1 : fend + 1) + 2;
    bad_tx = 0; bad_fl = 0; bad_d = 0; got_tx = 0; got_fl = 0;
    while (ec <= lim) begin
      step;
      exp_tx = (b < 0) && (ec >= r + 1);
      exp_fl = (ec >= a + 3) && (ec <= fend);
      if (tx_active != exp_tx) begin bad_tx++; got_tx = ec; end
      if (flush != exp_fl) begin bad_fl++; got_fl = ec; end
      if (dout != (tx_active ? din : '0)) bad_d++;
      if (ec == a + 3) cfg = c ^ 8'h40;
      if (b >= 0 && ec == b) pin = 0;
    end
    if (mode == 0)
      chk(bad_tx == 0, $sformatf("R3 R4 R5 R9 release edge cfg=%02h phase=%0d (mismatch at edge count)", c, phase), got_tx, r + 1);
    else
      chk(bad_tx == 0, $sformatf("R7 abort holds clamp mode=%0d (mismatch at edge count)", mode), got_tx, 0);
    chk(bad_fl == 0, $sformatf("R6 R7 flush window cfg=%02h phase=%0d (mismatch at edge count)", c, phase), got_fl, fend);
    chk(bad_d == 0, "R2 R5 output gating", bad_d, 0);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] codes [7];
    int phases [7];
    int bad;
    codes = '{8'h20, 8'h60, 8'h40, 8'hE0, 8'h21, 8'hFF, 8'h01};
    phases = '{0, 1, 31, 60, 61, 62, 63};
    repeat (4) step;
    chk(tx_active == 1 && flush == 0 && dout == din, "R1 state in reset", tx_active, 1);
    rst_n = 1;
    bad = 0;
    repeat (20) begin step; if (!(tx_active && !flush && dout == din)) bad++; end
    chk(bad == 0, "R1 low pin at reset does not clamp", bad, 0);
    pin = 1;
    bad = 0;
    repeat (12) begin step; if (!(tx_active && !flush && dout == din)) bad++; end
    chk(bad == 0, "R8 rise while passing ignored", bad, 0);
    drop_pin();
    for (int ph = 0; ph < 64; ph++) begin
      wake(8'h00, ph, 0);
      drop_pin();
    end
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        wake(codes[i], phases[j], 0);
        drop_pin();
      end
    end
    wake(8'h60, 10, 2);
    wake(8'h00, 5, 0);
    drop_pin();
    wake(8'h00, 40, 1);
    wake(8'h20, 63, 0);
    pin = 1;
    bad = 0;
    repeat (8) begin step; if (!(tx_active && !flush)) bad++; end
    chk(bad == 0, "R8 steady high pin keeps passing", bad, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule